// File: doc/BRIEF.md
# Wide Parallel BCD Adder

This block adds two packed decimal words of 16 digits (64 bits) in one pass. It does not walk the digits one at a time. It forms the plain binary sum and adds a bias of six to every digit of that sum. It then reads the decimal carry of each digit from the bit where the neighbouring digit begins. Every digit that carried gets a correction of six. The correction word comes from two shifts of the carry mask, so no chain of per-digit adders is needed.

The work is split over two register stages. The first stage holds the binary sum and the carry mask. The second stage holds the corrected result and an overflow flag that reports a decimal carry out of the top digit. A new operand pair can enter on every cycle, and there are no stalls. There is no carry input. Operands with digits above nine give undefined results.

Top module: `bcd_wide_adder`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o, ovf_o and sum_o are all zero until the first result emerges.
- R2: valid_o equals valid_i from two clock cycles earlier, for any pattern of valid_i, including back-to-back pairs.
- R3: For BCD operands, sum_o holds (a_i + b_i) mod 10^DIGITS in packed BCD. Digit k is at bits [4k+3:4k], and the least significant digit is at bits [3:0].
- R4: ovf_o is 1 exactly when the decimal sum of the operands is 10^DIGITS or more. It is presented together with the result on sum_o.
- R5: sum_o and ovf_o change only two cycles after a cycle in which valid_i was high. Otherwise they hold their last values, and a_i and b_i have no effect.
- R6: A carry ripples across every digit in the same pass: 99..99 + 1 gives all zeros with ovf_o = 1, and 99..99 + 99..99 gives 99..98 with ovf_o = 1.
- R7: Whenever valid_o is high for BCD operands, every nibble of sum_o is 9 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands on a_i and b_i are valid this cycle |
| a_i | input | 64 | First packed BCD operand |
| b_i | input | 64 | Second packed BCD operand |
| valid_o | output | 1 | sum_o and ovf_o carry a new result |
| sum_o | output | 64 | Packed BCD sum modulo 10^16 |
| ovf_o | output | 1 | Decimal carry out of the most significant digit |

## Verification
A wrong bit in the stage-one carry mask shows up on sum_o two cycles after the operands enter. The affected digit is off by six, usually as a nibble of 10 to 15, or it is missing its carry into the next digit. A lost top-digit carry shows as a wrong ovf_o in the same cycle. The bench places every digit pair at every position, with and without an incoming carry. This exposes a fault in any single digit's carry path on the first transaction that touches it. A broken valid pipeline shows as a valid_o that is early, late or missing relative to the stimulus, or as a sum_o that changes during a bubble.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd_presum.sv
module bcd_presum #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned W = DIGITS * bcd_add_pkg::DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] biased_o
);
  localparam logic [W-1:0] BIAS = {DIGITS{4'h6}};

  assign sum_o    = a_i + b_i;
  // +6 per digit turns a decimal carry into a binary carry at nibble edges
  assign biased_o = sum_o + BIAS;
endmodule

// File: rtl/bcd_carry_extract.sv
module bcd_carry_extract #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned DW = bcd_add_pkg::DIGIT_W,
  localparam int unsigned W = DIGITS * DW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] biased_i,
  output logic [W-1:0] mask_o
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    if (d < DIGITS - 1) begin : g_inner
      // carry into digit d+1 marks digit d as carrying
      assign mask_o[d*DW] = a_i[(d+1)*DW] ^ b_i[(d+1)*DW] ^ biased_i[(d+1)*DW];
    end else begin : g_top
      // biased sum wrapped below a => top digit carried
      assign mask_o[d*DW] = biased_i < a_i;
    end
    assign mask_o[d*DW+DW-1 -: DW-1] = '0;
  end
endmodule

// File: rtl/bcd_fixup.sv
module bcd_fixup #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned DW = bcd_add_pkg::DIGIT_W,
  localparam int unsigned W = DIGITS * DW
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] corr;

  // mask bits sit on nibble LSBs only, so x*6 = x<<1 | x<<2 without overlap
  assign corr  = (mask_i << 1) | (mask_i << 2);
  assign sum_o = sum_i + corr;
  assign ovf_o = mask_i[W-DW];
endmodule

// File: rtl/bcd_wide_adder.sv
module bcd_wide_adder #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned W = DIGITS * bcd_add_pkg::DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] bin_sum, biased, mask;
  logic         s1_valid;
  logic [W-1:0] s1_sum, s1_mask;
  logic [W-1:0] fix_sum;
  logic         fix_ovf;

  bcd_presum #(.DIGITS(DIGITS)) u_presum (
    .a_i(a_i), .b_i(b_i), .sum_o(bin_sum), .biased_o(biased)
  );

  bcd_carry_extract #(.DIGITS(DIGITS)) u_carry (
    .a_i(a_i), .b_i(b_i), .biased_i(biased), .mask_o(mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_mask  <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sum  <= bin_sum;
        s1_mask <= mask;
      end
    end
  end

  bcd_fixup #(.DIGITS(DIGITS)) u_fix (
    .sum_i(s1_sum), .mask_i(s1_mask), .sum_o(fix_sum), .ovf_o(fix_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        sum_o <= fix_sum;
        ovf_o <= fix_ovf;
      end
    end
  end
endmodule

// File: rtl/bcd_wide_adder_chk.sv
module bcd_wide_adder_chk #(
  parameter int unsigned DIGITS = 16,
  localparam int unsigned DW = bcd_add_pkg::DIGIT_W,
  localparam int unsigned W = DIGITS * DW
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         valid_o,
  input logic [W-1:0] sum_o,
  input logic         ovf_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic all_digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) ok &= bcd_add_pkg::digit_ok(v[d*DW +: DW]);
    return ok;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!valid_o && !ovf_o && sum_o == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2'd2 |-> valid_o == $past(valid_i, 2));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && !$past(valid_i, 2)) |-> ($stable(sum_o) && $stable(ovf_o)));

  p_digits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> all_digits_ok(sum_o));
endmodule

bind bcd_wide_adder bcd_wide_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .valid_o(valid_o), .sum_o(sum_o), .ovf_o(ovf_o)
);

// File: tb/sim_bcd_wide_adder.sv
`timescale 1ns/1ps
module sim_bcd_wide_adder;
  localparam int DIGITS = 16;
  localparam int W = DIGITS * 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         valid_o, ovf_o;
  logic [W-1:0] sum_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic         h0_v = 1'b0, h1_v = 1'b0, h0_o = 1'b0, h1_o = 1'b0, last_o = 1'b0;
  logic [W-1:0] h0_s = '0, h1_s = '0, last_s = '0;
  string        h0_r = "R3", h1_r = "R3";

  always #10 clk_i = ~clk_i;

  bcd_wide_adder #(.DIGITS(DIGITS)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .sum_o(sum_o), .ovf_o(ovf_o)
  );

  function automatic void ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] s, output logic o);
    int c = 0;
    s = '0;
    for (int d = 0; d < DIGITS; d++) begin
      int t = int'(a[d*4 +: 4]) + int'(b[d*4 +: 4]) + c;
      if (t >= 10) begin t -= 10; c = 1; end else c = 0;
      s[d*4 +: 4] = 4'(t);
    end
    o = (c != 0);
  endfunction

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] r;
    for (int d = 0; d < DIGITS; d++) r[d*4 +: 4] = 4'($urandom_range(0, 9));
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check what emerged for the pair driven two negedges ago, then drive
  task automatic cyc(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string req);
    logic [W-1:0] es;
    logic eo;
    @(negedge clk_i);
    check("R2 valid_o latency", W'(valid_o), W'(h1_v));
    if (h1_v) begin
      check({h1_r, " sum_o"}, sum_o, h1_s);
      check({h1_r, "/R4 ovf_o"}, W'(ovf_o), W'(h1_o));
      last_s = h1_s;
      last_o = h1_o;
    end else begin
      check("R5 sum_o hold", sum_o, last_s);
      check("R5 ovf_o hold", W'(ovf_o), W'(last_o));
    end
    ref_add(a, b, es, eo);
    h1_v = h0_v; h1_s = h0_s; h1_o = h0_o; h1_r = h0_r;
    h0_v = v; h0_s = es; h0_o = eo; h0_r = req;
    valid_i = v; a_i = a; b_i = b;
  endtask

  initial begin
    logic [W-1:0] nines, lower9;
    nines = {DIGITS{4'h9}};
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", W'(valid_o), '0);
    check("R1 sum_o in reset", sum_o, '0);
    rst_ni = 1'b1;
    check("R1 ovf_o after reset", W'(ovf_o), '0);

    // R6: full ripple corners
    cyc(1'b1, nines, W'(1), "R6");
    cyc(1'b1, nines, nines, "R6");
    cyc(1'b1, '0, '0, "R3");
    cyc(1'b1, nines, '0, "R6");
    cyc(1'b0, nines, nines, "R5");
    cyc(1'b0, '0, W'(1), "R5");

    // R3 R4: every digit pair at every position, with and without carry in
    for (int p = 0; p < DIGITS; p++) begin
      for (int ci = 0; ci < 2; ci++) begin
        if (p == 0 && ci == 1) continue;
        lower9 = (ci == 1) ? (nines >> (4 * (DIGITS - p))) : '0;
        for (int da = 0; da < 10; da++) begin
          for (int db = 0; db < 10; db++) begin
            cyc(1'b1, (W'(da) << (4 * p)) | lower9,
                (W'(db) << (4 * p)) | W'(ci), "R3");
          end
        end
      end
    end

    // random operands with random bubbles
    for (int i = 0; i < 3000; i++) begin
      cyc(1'($urandom_range(0, 3) != 0), rand_bcd(), rand_bcd(), "R3");
    end

    repeat (3) cyc(1'b0, rand_bcd(), rand_bcd(), "R5");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule